// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

This block produces a pulse-width modulated output from a free-running time base. The time base is an 8-bit timer with two fine sub-count bits below it, for 10 bits in all. A selectable prescaler paces the time base. An 8-bit period value sets when the timer wraps. A 10-bit duty value sets when the output falls within each period.

Software loads the duty in two pieces: an upper byte and a 2-bit low field, each with its own write strobe. Both pieces land in a holding register. The holding register is copied into a compare register only at the period wrap, so a duty change never cuts into the period already running. The compare register can be read back on a port.

A block enable and a pin-direction input together decide whether the pin driver is turned on. Clearing the enable releases the pin and parks the time base at zero.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: One output period lasts (period + 1) × 4 × N clocks. N is 1 for prescale select 0, 4 for select 1, and 16 for select 2 and for select 3.
- R2: For a 10-bit duty value D with 0 < D < (period + 1) × 4, the output is high for exactly D × N clocks in each period.
- R3: When the duty value committed at a wrap is zero, the output is not set and stays low for that whole period.
- R4: When the committed duty value is at least (period + 1) × 4, the output stays high through the period and across the wrap, with no low cycle.
- R5: A strobe on the upper-byte write loads duty bits 9:2. A strobe on the low-field write loads duty bits 1:0. A value written mid-period first shapes the output in the following period.
- R6: The compare register, readable on `slave_duty`, changes only at a period wrap, where it takes the holding register's value.
- R7: While `en` is low, `pwm_out` is low one clock later, the time base is held at zero, and `drive_en` is low. `drive_en` is high only when both `en` and `dir_out` are high.
- R8: After reset, the output is low and the compare register is zero. The first period after enabling starts with the time base at zero and keeps the output low.
- R9: The output rises on the clock edge at which the time base wraps, and only if the newly committed duty value is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low releases the pin and parks the time base |
| dir_out | input | 1 | Pin direction, 1 = output |
| psc_sel | input | 2 | Prescale select: 0 = /1, 1 = /4, 2 or 3 = /16 |
| period | input | 8 | Timer wrap value |
| duty_hi | input | 8 | Upper duty byte (duty bits 9:2) |
| duty_hi_wr | input | 1 | Write strobe for `duty_hi` |
| duty_lo | input | 2 | Low duty field (duty bits 1:0) |
| duty_lo_wr | input | 1 | Write strobe for `duty_lo` |
| pwm_out | output | 1 | PWM output |
| drive_en | output | 1 | Pin driver enable |
| slave_duty | output | 10 | Committed compare value, read-only |

## Verification
A wrong time-base or prescale count shows up within one period as a wrong period length or a wrong high time, counted in clocks between output edges. A compare register loaded at the wrong moment appears on `slave_duty`. It also stretches or shortens the high time of the period in which the mid-period write was made, rather than the next one. An output set wrongly at the wrap is visible on the very next clock, either as a rise under a zero duty or as a missing rise.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

   typedef enum logic [1:0] {
      PSC_DIV1   = 2'd0,
      PSC_DIV4   = 2'd1,
      PSC_DIV16A = 2'd2,
      PSC_DIV16B = 2'd3
   } psc_sel_e;

   // Last count value of the prescaler for a given select (divider - 1).
   function automatic int unsigned psc_last(input logic [1:0] sel);
      case (psc_sel_e'(sel))
         PSC_DIV1: return 0;
         PSC_DIV4: return 3;
         default:  return 15;
      endcase
   endfunction

endpackage

// File: rtl/pwm_psc.sv
module pwm_psc #(
   parameter int PSC_W   = 4,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   import pwm_dbuf_pkg::*;

   generate
      if (HAS_PSC) begin : g_psc
         if (PSC_W < 4) begin : g_bad_w
            $error("pwm_psc: PSC_W must be at least 4 to count to 16");
         end
         logic [PSC_W-1:0] cnt_q;
         logic [PSC_W-1:0] last;

         always_comb begin
            last = PSC_W'(psc_last(sel));
            // >= guards against a select change that leaves cnt_q past the new limit
            tick = run && (cnt_q >= last);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (!run || tick)  cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_nopsc
         logic unused_sel;
         assign unused_sel = ^{sel, clk, rst_n};
         assign tick = run;
      end
   endgenerate

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int TMR_W  = 8,
   parameter int FINE_W = 2,
   localparam int TB_W  = TMR_W + FINE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [TMR_W-1:0] period,
   output logic [TB_W-1:0]  tb_q,
   output logic [TB_W-1:0]  tb_nxt,
   output logic             roll
);

   logic last_phase;
   logic at_period;

   always_comb begin
      last_phase = &tb_q[FINE_W-1:0];
      at_period  = (tb_q[TB_W-1:FINE_W] == period);
      roll       = tick && last_phase && at_period;
      if (!tick)     tb_nxt = tb_q;
      else if (roll) tb_nxt = '0;
      else           tb_nxt = tb_q + 1'b1;   // fine bits carry into the timer
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tb_q <= '0;
      else if (!run) tb_q <= '0;
      else           tb_q <= tb_nxt;
   end

endmodule

// File: rtl/pwm_duty_regs.sv
module pwm_duty_regs #(
   parameter int HI_W  = 8,
   parameter int LO_W  = 2,
   localparam int D_W  = HI_W + LO_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [HI_W-1:0] hi_data,
   input  logic            hi_wr,
   input  logic [LO_W-1:0] lo_data,
   input  logic            lo_wr,
   input  logic            commit,
   output logic [D_W-1:0]  master_q,
   output logic [D_W-1:0]  slave_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q <= '0;
      end else begin
         if (hi_wr) master_q[D_W-1:LO_W] <= hi_data;
         if (lo_wr) master_q[LO_W-1:0]   <= lo_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slave_q <= '0;
      else if (commit) slave_q <= master_q;
   end

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen #(
   parameter int TMR_W   = 8,
   parameter int FINE_W  = 2,
   parameter int PSC_W   = 4,
   parameter bit HAS_PSC = 1'b1,
   localparam int DUTY_W = TMR_W + FINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              dir_out,
   input  logic [1:0]        psc_sel,
   input  logic [TMR_W-1:0]  period,
   input  logic [TMR_W-1:0]  duty_hi,
   input  logic              duty_hi_wr,
   input  logic [FINE_W-1:0] duty_lo,
   input  logic              duty_lo_wr,
   output logic              pwm_out,
   output logic              drive_en,
   output logic [DUTY_W-1:0] slave_duty
);

   generate
      if (TMR_W < 2 || TMR_W > 16) begin : g_bad_tmr
         $error("pwm_dbuf_gen: TMR_W out of range 2..16");
      end
      if (FINE_W != 2) begin : g_bad_fine
         $error("pwm_dbuf_gen: the sub-count must be two bits (four phases)");
      end
   endgenerate

   logic              tick_w;
   logic              roll_w;
   logic [DUTY_W-1:0] tb_w;
   logic [DUTY_W-1:0] tb_nxt_w;
   logic [DUTY_W-1:0] master_w;
   logic              out_q;

   pwm_psc #(
      .PSC_W   (PSC_W),
      .HAS_PSC (HAS_PSC)
   ) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en),
      .sel   (psc_sel),
      .tick  (tick_w)
   );

   pwm_timebase #(
      .TMR_W  (TMR_W),
      .FINE_W (FINE_W)
   ) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (en),
      .tick   (tick_w),
      .period (period),
      .tb_q   (tb_w),
      .tb_nxt (tb_nxt_w),
      .roll   (roll_w)
   );

   pwm_duty_regs #(
      .HI_W (TMR_W),
      .LO_W (FINE_W)
   ) u_duty (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi_data  (duty_hi),
      .hi_wr    (duty_hi_wr),
      .lo_data  (duty_lo),
      .lo_wr    (duty_lo_wr),
      .commit   (roll_w),
      .master_q (master_w),
      .slave_q  (slave_duty)
   );

   // Set at the wrap (unless the new duty is zero), clear when the
   // time base steps onto the committed compare value.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 out_q <= 1'b0;
      else if (!en)                               out_q <= 1'b0;
      else if (roll_w)                            out_q <= (master_w != '0);
      else if (tick_w && (tb_nxt_w == slave_duty)) out_q <= 1'b0;
   end

   assign pwm_out  = out_q;
   assign drive_en = en & dir_out;

endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
   parameter int DUTY_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              roll,
   input logic [DUTY_W-1:0] master,
   input logic [DUTY_W-1:0] slave,
   input logic [DUTY_W-1:0] tb,
   input logic              pwm_out,
   input logic              drive_en
);

   assert_slave_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !roll |=> $stable(slave));

   assert_slave_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      roll |=> (slave == $past(master)));

   assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (roll && master == '0) |=> !pwm_out);

   assert_wrap_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (roll && master != '0) |=> pwm_out);

   assert_wrap_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      roll |=> (tb == '0));

   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pwm_out && tb == '0));

   assert_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !drive_en);

endmodule

bind pwm_dbuf_gen pwm_dbuf_chk #(.DUTY_W(DUTY_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .roll     (roll_w),
   .master   (master_w),
   .slave    (slave_duty),
   .tb       (tb_w),
   .pwm_out  (pwm_out),
   .drive_en (drive_en)
);

// File: tb/pwm_dbuf_gen_bench.sv
module pwm_dbuf_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       dir_out = 1'b0;
   logic [1:0] psc_sel = 2'd0;
   logic [7:0] period = 8'd0;
   logic [7:0] duty_hi = 8'd0;
   logic       duty_hi_wr = 1'b0;
   logic [1:0] duty_lo = 2'd0;
   logic       duty_lo_wr = 1'b0;
   logic       pwm_out;
   logic       drive_en;
   logic [9:0] slave_duty;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   localparam int LIM  = 5000;
   localparam int NVEC = 7;
   // psc_sel, period, duty (10 bit), expected high clocks, expected period clocks
   localparam int V_PSC [NVEC] = '{0,   1,   2,   0,    0, 1,  3};
   localparam int V_PER [NVEC] = '{3,   9,   2,   255,  0, 4,  1};
   localparam int V_DUT [NVEC] = '{5,   17,  11,  1023, 3, 1,  2};
   localparam int V_HI  [NVEC] = '{5,   68,  176, 1023, 3, 4,  32};
   localparam int V_PRD [NVEC] = '{16,  160, 192, 1024, 4, 80, 128};

   pwm_dbuf_gen u_pwm_dbuf_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .dir_out    (dir_out),
      .psc_sel    (psc_sel),
      .period     (period),
      .duty_hi    (duty_hi),
      .duty_hi_wr (duty_hi_wr),
      .duty_lo    (duty_lo),
      .duty_lo_wr (duty_lo_wr),
      .pwm_out    (pwm_out),
      .drive_en   (drive_en),
      .slave_duty (slave_duty)
   );

   always #2 clk = ~clk;

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic setup(input int psc, input int per, input int duty);
      @(negedge clk);
      en         = 1'b0;
      psc_sel    = 2'(psc);
      period     = 8'(per);
      duty_hi    = 8'(duty >> 2);
      duty_lo    = 2'(duty);
      duty_hi_wr = 1'b1;
      duty_lo_wr = 1'b1;
      @(negedge clk);
      duty_hi_wr = 1'b0;
      duty_lo_wr = 1'b0;
      en         = 1'b1;
   endtask

   task automatic wait_rise();
      int n = 0;
      while (!pwm_out && n < LIM) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic measure(output int h, output int p);
      h = 0;
      while (pwm_out && h < LIM) begin
         h++;
         @(negedge clk);
      end
      p = h;
      while (!pwm_out && p < LIM) begin
         p++;
         @(negedge clk);
      end
   endtask

   task automatic count_high(input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out) hi++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int h;
      int p;
      int cnt;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8", "pwm_out in reset", int'(pwm_out), 0);
      check("R8", "slave_duty in reset", int'(slave_duty), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7", "drive_en with en low", int'(drive_en), 0);

      // R8: first period after enabling stays low, then R2 duty applies
      setup(0, 3, 5);
      dir_out = 1'b1;
      count_high(15, cnt);
      check("R8", "high clocks in first period", cnt, 0);
      check("R7", "drive_en with en and dir set", int'(drive_en), 1);
      dir_out = 1'b0;
      @(negedge clk);
      check("R7", "drive_en with dir clear", int'(drive_en), 0);
      wait_rise();
      measure(h, p);
      check("R2", "high clocks after first wrap", h, 5);

      // R1 R2 R4: table walk
      for (int v = 0; v < NVEC; v++) begin
         setup(V_PSC[v], V_PER[v], V_DUT[v]);
         wait_rise();
         measure(h, p);
         check("R2", $sformatf("high clocks vec%0d", v), h, V_HI[v]);
         check("R1", $sformatf("period clocks vec%0d", v), p, V_PRD[v]);
      end

      // R3: zero duty never sets the output
      setup(0, 3, 0);
      count_high(64, cnt);
      check("R3", "high clocks with zero duty", cnt, 0);
      check("R3", "slave_duty with zero duty", int'(slave_duty), 0);

      // R4: duty beyond the period keeps the output high across wraps
      setup(0, 3, 40);
      wait_rise();
      count_high(48, cnt);
      check("R4", "high clocks with full duty", cnt, 48);
      check("R6", "slave_duty after commit", int'(slave_duty), 40);

      // R7: clearing the enable releases the output
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R7", "pwm_out after disable", int'(pwm_out), 0);
      check("R7", "drive_en after disable", int'(drive_en), 0);

      // R5 R6: mid-period writes take effect only in the next period
      setup(0, 7, 8);
      wait_rise();
      measure(h, p);
      check("R5", "high clocks before write", h, 8);
      while (pwm_out) @(negedge clk);
      duty_hi    = 8'd5;
      duty_hi_wr = 1'b1;
      @(negedge clk);
      duty_hi_wr = 1'b0;
      @(negedge clk);
      check("R6", "slave_duty holds mid-period", int'(slave_duty), 8);
      wait_rise();
      check("R6", "slave_duty after wrap", int'(slave_duty), 20);
      measure(h, p);
      check("R5", "high clocks after upper-byte write", h, 20);
      while (pwm_out) @(negedge clk);
      duty_lo    = 2'd2;
      duty_lo_wr = 1'b1;
      @(negedge clk);
      duty_lo_wr = 1'b0;
      wait_rise();
      measure(h, p);
      check("R5", "high clocks after low-field write", h, 22);
      check("R9", "period clocks after low-field write", p, 32);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule